// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a real-time calendar clock. It holds seconds, minutes, hours, day of month, month and a two-digit year as packed BCD, and it covers the century 2000 to 2099. A slow tick input carries one single-cycle pulse per period of a 32.768 kHz oscillator, synchronous to the system clock. A prescaler counts those pulses and advances the calendar by one second each time a full second of ticks has been seen. Each carry follows the real calendar: months have 28, 29, 30 or 31 days, and February has 29 days in every year divisible by four.

A byte-wide register bus gives software access to the time, a six-field alarm, a run control, a status register and interrupt enables. The alarm has no wildcard fields. It fires only when every one of the six fields matches the time the clock has just advanced to. The status register shows a busy window during the last tick period before each update. It also holds two sticky event flags, one for each second and one for the alarm, and each is cleared by writing 1 to it. Two interrupt outputs follow the event flags through their enables.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset the time reads 00 seconds, 00 minutes, 00 hours, day 0x01, month 0x01, year 0x00. Control, status and interrupt enable all read 0x00, and the clock is stopped.
- R2: While control bit 0 is 1, the seconds field advances once every TICKS_PER_SEC tick pulses. A bus write to any time register sets the value at once and restarts the tick count from zero.
- R3: Seconds and minutes wrap from 0x59 to 0x00 and carry into the next field. Hours wrap from 0x23 to 0x00 and carry into the day.
- R4: The day wraps to 0x01 after the last day of the month: 31, 30 (April, June, September, November), 28 for February, or 29 for February when the binary year value is divisible by 4 (year 00 included).
- R5: The month wraps from 0x12 to 0x01 and carries into the year. The year wraps from 0x99 to 0x00.
- R6: While control bit 0 is 0, ticks do not change the time. Status bit 1 reads as control bit 0.
- R7: Status bit 0 (busy) is 1 exactly while the clock is running and the tick count stands one tick before the next seconds update. It reads 0 again after the update.
- R8: Alarm registers sit at 0x20, 0x24, 0x28, 0x2C, 0x30 and 0x34 (seconds, minutes, hours, day, month, year) and read back what was written. Status bit 6 is set when the clock advances to a time equal to all six alarm fields. A difference in any one field prevents it.
- R9: Writing 1 to status bit 6 or bit 2 clears that flag. Writing 0 leaves it as it was.
- R10: Output irq_alarm is status bit 6 AND interrupt-enable (0x48) bit 3. Output irq_timer is status bit 2 AND interrupt-enable bit 2. Both are registered.
- R11: Status bit 2 is set at every seconds advance.
- R12: Only control bit 0 is stored. Control bit 3 (12-hour select) and the other bits read 0 whatever is written, so the clock always counts 24 hours.
- R13: Time registers sit at 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 (seconds, minutes, hours, day, month, year). Control is at 0x40, status at 0x44 and interrupt enable at 0x48. Read data appears one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per 32.768 kHz period |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for bus_addr |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_timer | output | 1 | One-second interrupt |

## Verification
The bench drives the hard carries directly: the end of the century on New Year's Eve, February 28 and 29 in leap and common years (year 00 included), and the end of a 30-day month. A design with a wrong month-length table or a wrong leap test would show an impossible date such as February 30, or it would skip February 29. The alarm test shows that nothing fires one second early and that a mismatch in the year alone keeps the flag low. A design that compares only part of the time would raise the flag on the wrong day. Busy is sampled one tick before the update and again after it, and the stop test sends ticks while the clock is halted. Random dates, weighted toward the end of minutes, are compared against a calendar model in the bench after random numbers of seconds.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
  localparam int NFIELD = 6;
  localparam logic [7:0] ADR_CTRL = 8'h40;
  localparam logic [7:0] ADR_STAT = 8'h44;
  localparam logic [7:0] ADR_IE   = 8'h48;

  // field indices: 0 sec, 1 min, 2 hour, 3 day, 4 month, 5 year
  localparam int F_SEC = 0, F_MIN = 1, F_HOUR = 2, F_DAY = 3, F_MON = 4, F_YEAR = 5;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] year);
    logic [6:0] ybin;
    logic leap;
    ybin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
    leap = (ybin[1:0] == 2'b00);
    case (mon)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic restart,
  output logic step,
  output logic busy
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign busy = run && (cnt_q == LAST);
  assign step = busy && tick && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_bcd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step,
  input  logic [NFIELD-1:0]      wr_en,
  input  logic [7:0]             wdata,
  output logic [NFIELD-1:0][7:0] now
);
  logic [NFIELD-1:0][7:0] t_q, t_d;
  logic c_sec, c_min, c_hour, c_day, c_mon;

  always_comb begin
    t_d = t_q;
    c_sec  = step && (t_q[F_SEC] >= 8'h59);
    c_min  = c_sec && (t_q[F_MIN] >= 8'h59);
    c_hour = c_min && (t_q[F_HOUR] >= 8'h23);
    c_day  = c_hour && (t_q[F_DAY] >= month_end(t_q[F_MON], t_q[F_YEAR]));
    c_mon  = c_day && (t_q[F_MON] >= 8'h12);
    if (step)   t_d[F_SEC]  = c_sec  ? 8'h00 : bcd_inc(t_q[F_SEC]);
    if (c_sec)  t_d[F_MIN]  = c_min  ? 8'h00 : bcd_inc(t_q[F_MIN]);
    if (c_min)  t_d[F_HOUR] = c_hour ? 8'h00 : bcd_inc(t_q[F_HOUR]);
    if (c_hour) t_d[F_DAY]  = c_day  ? 8'h01 : bcd_inc(t_q[F_DAY]);
    if (c_day)  t_d[F_MON]  = c_mon  ? 8'h01 : bcd_inc(t_q[F_MON]);
    if (c_mon)  t_d[F_YEAR] = (t_q[F_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(t_q[F_YEAR]);
    for (int i = 0; i < NFIELD; i++) begin
      if (wr_en[i]) t_d[i] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q <= '0;
      t_q[F_DAY] <= 8'h01;
      t_q[F_MON] <= 8'h01;
    end else begin
      t_q <= t_d;
    end
  end

  assign now = t_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_bcd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NFIELD-1:0]      wr_en,
  input  logic [7:0]             wdata,
  input  logic [NFIELD-1:0][7:0] now,
  output logic [NFIELD-1:0][7:0] alarm,
  output logic                   match
);
  logic [NFIELD-1:0] eq;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    logic [7:0] a_q;
    always_ff @(posedge clk) begin
      if (rst) a_q <= 8'h00;
      else if (wr_en[g]) a_q <= wdata;
    end
    assign alarm[g] = a_q;
    assign eq[g] = (a_q == now[g]);
  end

  assign match = &eq;
endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_bcd_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [7:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_alarm,
  output logic       irq_timer
);
  logic [NFIELD-1:0]      time_wr, alarm_wr;
  logic                   any_time_wr;
  logic [NFIELD-1:0][7:0] now, alarm;
  logic                   match, step, busy;
  logic                   ctrl_run, ie_alarm, ie_timer;
  logic                   flag_alarm, flag_sec, step_d;
  logic                   field_ok;
  logic [2:0]             fidx;
  logic                   stat_wr;
  logic [7:0]             rd_mux;

  assign fidx     = bus_addr[4:2];
  assign field_ok = (bus_addr[1:0] == 2'b00) && (fidx < 3'(NFIELD));

  always_comb begin
    for (int i = 0; i < NFIELD; i++) begin
      time_wr[i]  = bus_we && field_ok && (bus_addr[7:5] == 3'b000) && (fidx == 3'(i));
      alarm_wr[i] = bus_we && field_ok && (bus_addr[7:5] == 3'b001) && (fidx == 3'(i));
    end
  end
  assign any_time_wr = |time_wr;
  assign stat_wr     = bus_we && (bus_addr == ADR_STAT);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst(rst), .run(ctrl_run), .tick(tick),
    .restart(any_time_wr), .step(step), .busy(busy)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .step(step), .wr_en(time_wr),
    .wdata(bus_wdata), .now(now)
  );

  rtc_alarm u_alm (
    .clk(clk), .rst(rst), .wr_en(alarm_wr), .wdata(bus_wdata),
    .now(now), .alarm(alarm), .match(match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_run   <= 1'b0;
      ie_alarm   <= 1'b0;
      ie_timer   <= 1'b0;
      flag_alarm <= 1'b0;
      flag_sec   <= 1'b0;
      step_d     <= 1'b0;
      irq_alarm  <= 1'b0;
      irq_timer  <= 1'b0;
    end else begin
      step_d <= step;
      if (bus_we && bus_addr == ADR_CTRL) ctrl_run <= bus_wdata[0];
      if (bus_we && bus_addr == ADR_IE) begin
        ie_alarm <= bus_wdata[3];
        ie_timer <= bus_wdata[2];
      end
      if (step_d && match) flag_alarm <= 1'b1;
      else if (stat_wr && bus_wdata[6]) flag_alarm <= 1'b0;
      if (step) flag_sec <= 1'b1;
      else if (stat_wr && bus_wdata[2]) flag_sec <= 1'b0;
      irq_alarm <= flag_alarm && ie_alarm;
      irq_timer <= flag_sec && ie_timer;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (field_ok && bus_addr[7:5] == 3'b000) rd_mux = now[fidx];
    else if (field_ok && bus_addr[7:5] == 3'b001) rd_mux = alarm[fidx];
    else if (bus_addr == ADR_CTRL) rd_mux = {7'b0, ctrl_run};
    else if (bus_addr == ADR_STAT) rd_mux = {1'b0, flag_alarm, 3'b000, flag_sec, ctrl_run, busy};
    else if (bus_addr == ADR_IE)   rd_mux = {4'b0, ie_alarm, ie_timer, 2'b00};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 8'h00;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_bcd_clock_chk.sv
module rtc_bcd_clock_chk (
  input logic        clk,
  input logic        rst,
  input logic        run,
  input logic        busy,
  input logic        step,
  input logic        any_time_wr,
  input logic [47:0] now_vec,
  input logic        flag_alarm,
  input logic        match
);
  // R7: busy only while running
  assert_busy_needs_run_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> run);

  // R6: a halted clock keeps its time unless software writes it
  assert_stop_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!run && !any_time_wr) |=> $stable(now_vec));

  // R2: time moves only on a prescaler step or a bus write
  assert_change_on_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!step && !any_time_wr) |=> $stable(now_vec));

  // R3: seconds remain valid BCD 00..59
  assert_sec_range_R3: assert property (@(posedge clk) disable iff (rst)
    (now_vec[3:0] <= 4'd9) && (now_vec[7:0] <= 8'h59));

  // R5: month remains 01..12
  assert_month_range_R5: assert property (@(posedge clk) disable iff (rst)
    (now_vec[39:32] >= 8'h01) && (now_vec[39:32] <= 8'h12));

  // R8: the alarm flag only rises after a full six-field match
  assert_alarm_needs_match_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_alarm) |-> $past(match));
endmodule

bind rtc_bcd_clock rtc_bcd_clock_chk u_chk (
  .clk(clk), .rst(rst), .run(ctrl_run), .busy(busy), .step(step),
  .any_time_wr(any_time_wr), .now_vec(now), .flag_alarm(flag_alarm),
  .match(match)
);

// File: tb/rtc_bcd_clock_bench.sv
module rtc_bcd_clock_bench;
  localparam int TPS = 4;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq_alarm, irq_timer;
  int checks = 0, errors = 0;
  int my, mmo, md, mh, mmi, ms;

  always #2.5 clk = ~clk;

  rtc_bcd_clock #(.TICKS_PER_SEC(TPS)) u_rtc_bcd_clock (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_alarm(irq_alarm), .irq_timer(irq_timer)
  );

  function automatic logic [7:0] bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    ms++;
    if (ms == 60) begin ms = 0; mmi++; end
    if (mmi == 60) begin mmi = 0; mh++; end
    if (mh == 24) begin mh = 0; md++; end
    if (md > mdays(mmo, my)) begin md = 1; mmo++; end
    if (mmo == 13) begin mmo = 1; my++; end
    if (my == 100) my = 0;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic seconds(input int n);
    ticks(n * TPS);
    for (int i = 0; i < n; i++) model_step();
  endtask

  task automatic set_time(input int y, mo, d, h, mi, s);
    my = y; mmo = mo; md = d; mh = h; mmi = mi; ms = s;
    wr(8'h14, bcd(y)); wr(8'h10, bcd(mo)); wr(8'h0C, bcd(d));
    wr(8'h08, bcd(h)); wr(8'h04, bcd(mi)); wr(8'h00, bcd(s));
  endtask

  task automatic cmp_time(input string req);
    logic [7:0] v;
    rd(8'h00, v); check(req, v, bcd(ms));
    rd(8'h04, v); check(req, v, bcd(mmi));
    rd(8'h08, v); check(req, v, bcd(mh));
    rd(8'h0C, v); check(req, v, bcd(md));
    rd(8'h10, v); check(req, v, bcd(mo_get()));
    rd(8'h14, v); check(req, v, bcd(my));
  endtask

  function automatic int mo_get();
    return mmo;
  endfunction

  task automatic set_alarm(input int y, mo, d, h, mi, s);
    wr(8'h34, bcd(y)); wr(8'h30, bcd(mo)); wr(8'h2C, bcd(d));
    wr(8'h28, bcd(h)); wr(8'h24, bcd(mi)); wr(8'h20, bcd(s));
  endtask

  initial begin
    #750000;
    checks++; errors++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    my = 0; mmo = 1; md = 1; mh = 0; mmi = 0; ms = 0;

    // R1 / R13 reset state at the documented offsets
    cmp_time("R1");
    rd(8'h40, v); check("R1 ctrl", v, 8'h00);
    rd(8'h44, v); check("R1 status", v, 8'h00);
    rd(8'h48, v); check("R1 ie", v, 8'h00);
    ticks(2 * TPS);
    rd(8'h00, v); check("R1 stopped after reset", v, 8'h00);

    // R12 only run bit stored; R6 run mirrored in status
    wr(8'h40, 8'hFF);
    rd(8'h40, v); check("R12 ctrl readback", v, 8'h01);
    rd(8'h44, v); check("R6 status run bit", v & 8'h02, 8'h02);

    // R2 / R7 prescaler and busy window
    set_time(10, 3, 5, 7, 8, 9);
    ticks(TPS - 2);
    rd(8'h44, v); check("R7 busy low early", v & 8'h01, 8'h00);
    ticks(1);
    rd(8'h44, v); check("R7 busy one tick before", v & 8'h01, 8'h01);
    rd(8'h00, v); check("R2 no advance yet", v, 8'h09);
    ticks(1);
    model_step();
    rd(8'h44, v); check("R7 busy low after update", v & 8'h01, 8'h00);
    rd(8'h00, v); check("R2 advanced", v, 8'h10);
    ticks(TPS - 1);
    wr(8'h00, 8'h30); ms = 30;
    ticks(TPS - 1);
    rd(8'h00, v); check("R2 restart on write", v, 8'h30);

    // R3 R4 R5 directed rollovers
    set_time(99, 12, 31, 23, 59, 59); seconds(1); cmp_time("R5 century");
    set_time(4, 2, 28, 23, 59, 59);   seconds(1); cmp_time("R4 leap feb28");
    set_time(3, 2, 28, 23, 59, 59);   seconds(1); cmp_time("R4 common feb28");
    set_time(4, 2, 29, 23, 59, 59);   seconds(1); cmp_time("R4 leap feb29");
    set_time(0, 2, 28, 23, 59, 59);   seconds(1); cmp_time("R4 year00 leap");
    set_time(21, 4, 30, 23, 59, 59);  seconds(1); cmp_time("R4 30-day month");
    set_time(21, 7, 9, 9, 59, 59);    seconds(1); cmp_time("R3 hour carry");

    // R6 stop holds time
    wr(8'h40, 8'h00);
    rd(8'h44, v); check("R6 status run clear", v & 8'h02, 8'h00);
    ticks(3 * TPS);
    cmp_time("R6 held while stopped");
    wr(8'h40, 8'h01);

    // R11 / R9 one-second flag
    wr(8'h44, 8'hFF);
    rd(8'h44, v); check("R9 cleared", v & 8'h44, 8'h00);
    seconds(1);
    rd(8'h44, v); check("R11 sec flag set", v & 8'h04, 8'h04);
    wr(8'h44, 8'h00);
    rd(8'h44, v); check("R9 write 0 keeps", v & 8'h04, 8'h04);
    wr(8'h44, 8'h04);
    rd(8'h44, v); check("R9 write 1 clears", v & 8'h04, 8'h00);

    // R10 timer interrupt
    wr(8'h48, 8'h04);
    rd(8'h48, v); check("R10 ie readback", v, 8'h04);
    seconds(1);
    check("R10 irq_timer on", {7'b0, irq_timer}, 8'h01);
    wr(8'h44, 8'h04); repeat (3) @(negedge clk);
    check("R10 irq_timer off", {7'b0, irq_timer}, 8'h00);
    wr(8'h48, 8'h00);
    seconds(1);
    check("R10 irq_timer gated", {7'b0, irq_timer}, 8'h00);

    // R8 alarm full match
    set_time(10, 6, 15, 12, 30, 20);
    set_alarm(10, 6, 15, 12, 30, 22);
    rd(8'h20, v); check("R8 alarm sec readback", v, 8'h22);
    rd(8'h2C, v); check("R8 alarm day readback", v, 8'h15);
    rd(8'h34, v); check("R8 alarm year readback", v, 8'h10);
    wr(8'h48, 8'h08);
    wr(8'h44, 8'h44);
    seconds(1);
    rd(8'h44, v); check("R8 not early", v & 8'h40, 8'h00);
    check("R10 irq_alarm low early", {7'b0, irq_alarm}, 8'h00);
    seconds(1);
    rd(8'h44, v); check("R8 alarm fires", v & 8'h40, 8'h40);
    check("R10 irq_alarm high", {7'b0, irq_alarm}, 8'h01);
    wr(8'h44, 8'h40); repeat (3) @(negedge clk);
    rd(8'h44, v); check("R9 alarm cleared", v & 8'h40, 8'h00);
    check("R10 irq_alarm cleared", {7'b0, irq_alarm}, 8'h00);

    // R8 year-only mismatch
    set_time(10, 6, 15, 12, 30, 20);
    set_alarm(11, 6, 15, 12, 30, 22);
    seconds(3);
    rd(8'h44, v); check("R8 year mismatch", v & 8'h40, 8'h00);
    wr(8'h48, 8'h00);

    // R3 R4 R5 random dates vs model
    for (int it = 0; it < 40; it++) begin
      int y, mo, d, h, mi, s, k;
      y = $urandom_range(0, 99); mo = $urandom_range(1, 12);
      d = ($urandom_range(0, 1) == 1) ? mdays(mo, y) : $urandom_range(1, mdays(mo, y));
      h = ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23);
      mi = ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59);
      s = $urandom_range(50, 59);
      k = $urandom_range(1, 12);
      set_time(y, mo, d, h, mi, s);
      seconds(k);
      cmp_time("R3 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule